// File: doc/BRIEF.md
# Bit-Band Alias Address Bridge

This bridge sits between a bus master and a word-addressed register or memory space. Each 4-byte word in a 32 MB alias window stands for one bit of a 1 MB bit-band window. An access that lands in the alias window is converted into an access on the word that holds that bit. An alias read returns only the addressed bit. An alias write sets or clears only that bit by running a read, a modify and a write on the target word as one locked sequence.

Addresses outside the alias window go downstream unchanged. Both sides use a valid/ready request channel that carries address, write enable, write data and read data. A transfer completes in the cycle where valid and ready are both high, and read data is valid in that same cycle. Software can therefore toggle one output pin or flag with a single store, and no other bits of the word are touched.

Top module: `bitalias_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it is released with no request, up_ready and dn_valid are both 0.
- R2: An access outside the alias window is forwarded downstream with the same address, write enable and write data. The downstream read data is returned unchanged. dn_valid first rises one cycle after the request is seen, so with a ready target the upstream transfer completes in the second cycle of the request.
- R3: The alias window is [0x42000000, 0x44000000). The addresses 0x44000000 and 0x41FFFFFC are passed through as full-word accesses.
- R4: For an alias address A, the target word address is 0x40000000 plus A[24:5] with its two low bits cleared. The bit position in that word is A[6:5]*8 + A[4:2]. For example, 0x42000000 maps to bit 0 of 0x40000000, and 0x43FFFFFC maps to bit 31 of 0x400FFFFC.
- R5: An alias read makes one downstream read of the target word. It returns the addressed bit in up_rdata[0], with up_rdata[31:1] equal to 0.
- R6: An alias write makes a downstream read and then a downstream write to the same word address. The written word equals the word that was read, with only the addressed bit replaced by up_wdata[0].
- R7: On an alias write, bits [31:1] of up_wdata have no effect on the stored word.
- R8: During an alias write, up_ready stays 0 until the downstream write completes, and no other downstream transfer occurs between the read and the write. up_ready is only ever 1 in a cycle with a downstream handshake. With a ready target, an alias write completes in the third cycle of the request and an alias read in the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_valid | input | 1 | Master request valid |
| up_ready | output | 1 | Request complete; up_rdata valid this cycle |
| up_addr | input | 32 | Master byte address |
| up_we | input | 1 | Master write enable |
| up_wdata | input | 32 | Master write data |
| up_rdata | output | 32 | Read data to master |
| dn_valid | output | 1 | Target request valid |
| dn_ready | input | 1 | Target accepts and completes the request |
| dn_addr | output | 32 | Target byte address |
| dn_we | output | 1 | Target write enable |
| dn_wdata | output | 32 | Target write data |
| dn_rdata | input | 32 | Target read data, valid with dn_ready |

## Verification
The assertions rely on two assumptions. First, the master holds up_valid, up_addr, up_we and up_wdata stable from the moment it raises valid until it sees up_ready. Second, the target does not change the word between the read and the write phases of an alias write, so the one-bit-difference check between the read and write data is meaningful. The bench meets both assumptions. It changes requests only at the falling edge, right after the completing edge. Its memory model has only this bridge as a writer. The bench also stalls the target with a periodic ready pattern, and ready changes only at rising edges.

// File: rtl/bab_pkg.sv
package bab_pkg;
   // sequencer states of the bridge
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,   // waiting for a request, decode in progress
      ST_PASS = 2'd1,   // forwarding an access outside the alias window
      ST_RD   = 2'd2,   // alias access: reading the target word
      ST_WR   = 2'd3    // alias write: writing the modified word back
   } bab_state_e;

   // each band bit occupies one 4-byte alias word: 32 alias bytes per band byte
   localparam int unsigned ALIAS_SHIFT = 5;
endpackage

// File: rtl/bab_decode.sv
module bab_decode #(
   parameter int unsigned          ADDR_W     = 32,
   parameter int unsigned          DATA_W     = 32,
   parameter int unsigned          BAND_LOG2  = 20,
   parameter logic [ADDR_W-1:0]    BAND_BASE  = 32'h4000_0000,
   parameter logic [ADDR_W-1:0]    ALIAS_BASE = 32'h4200_0000,
   localparam int unsigned         ALIAS_LOG2 = BAND_LOG2 + bab_pkg::ALIAS_SHIFT,
   localparam int unsigned         LANE_W     = $clog2(DATA_W / 8),
   localparam int unsigned         POS_W      = $clog2(DATA_W)
) (
   input  logic [ADDR_W-3:0] addr_word,   // byte address without its two low bits
   output logic              is_alias,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic [POS_W-1:0]  tgt_pos
);
   logic [BAND_LOG2-1:0] byte_off;
   logic [2:0]           bit_in_byte;

   assign is_alias    = (addr_word[ADDR_W-3:ALIAS_LOG2-2] == ALIAS_BASE[ADDR_W-1:ALIAS_LOG2]);
   assign byte_off    = addr_word[ALIAS_LOG2-3:3];
   assign bit_in_byte = addr_word[2:0];
   assign tgt_addr    = BAND_BASE + ADDR_W'({byte_off[BAND_LOG2-1:LANE_W], {LANE_W{1'b0}}});
   assign tgt_pos     = {byte_off[LANE_W-1:0], bit_in_byte};
endmodule

// File: rtl/bab_bitmod.sv
module bab_bitmod #(
   parameter int unsigned  DATA_W = 32,
   localparam int unsigned POS_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] word_in,
   input  logic [POS_W-1:0]  pos,
   input  logic              new_val,
   output logic              bit_out,
   output logic [DATA_W-1:0] word_out
);
   assign bit_out = word_in[pos];

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_lane
      assign word_out[gi] = (pos == POS_W'(gi)) ? new_val : word_in[gi];
   end
endmodule

// File: rtl/bab_seq.sv
module bab_seq
   import bab_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic       req_we,
   input  logic       req_alias,
   input  logic       tgt_ready,
   output bab_state_e state
);
   bab_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (req)       nxt = req_alias ? ST_RD : ST_PASS;
         ST_PASS: if (tgt_ready) nxt = ST_IDLE;
         ST_RD:   if (tgt_ready) nxt = req_we ? ST_WR : ST_IDLE;
         ST_WR:   if (tgt_ready) nxt = ST_IDLE;
         default:                nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/bitalias_bridge.sv
module bitalias_bridge
   import bab_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       BAND_LOG2  = 20,
   parameter logic [ADDR_W-1:0] BAND_BASE  = 32'h4000_0000,
   parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h4200_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic              up_we,
   input  logic [DATA_W-1:0] up_wdata,
   output logic [DATA_W-1:0] up_rdata,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic [ADDR_W-1:0] dn_addr,
   output logic              dn_we,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic [DATA_W-1:0] dn_rdata
);
   localparam int unsigned ALIAS_LOG2 = BAND_LOG2 + ALIAS_SHIFT;
   localparam int unsigned POS_W      = $clog2(DATA_W);

   // elaboration-time parameter checks
   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_width
      $error("bitalias_bridge: DATA_W must be 32 or 64");
   end
   if (ADDR_W <= ALIAS_LOG2) begin : g_bad_addr
      $error("bitalias_bridge: ADDR_W too small for alias window");
   end
   if (ALIAS_BASE[ALIAS_LOG2-1:0] != '0) begin : g_bad_alias_base
      $error("bitalias_bridge: ALIAS_BASE must be aligned to the alias window size");
   end
   if (BAND_BASE[BAND_LOG2-1:0] != '0) begin : g_bad_band_base
      $error("bitalias_bridge: BAND_BASE must be aligned to the band size");
   end

   bab_state_e        state;
   logic              is_alias;
   logic [ADDR_W-1:0] tgt_addr;
   logic [POS_W-1:0]  tgt_pos;
   logic              tgt_bit;
   logic [DATA_W-1:0] mod_word;
   logic [DATA_W-1:0] mod_q;

   bab_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BAND_LOG2(BAND_LOG2),
      .BAND_BASE(BAND_BASE), .ALIAS_BASE(ALIAS_BASE)
   ) u_decode (
      .addr_word (up_addr[ADDR_W-1:2]),
      .is_alias  (is_alias),
      .tgt_addr  (tgt_addr),
      .tgt_pos   (tgt_pos)
   );

   bab_bitmod #(.DATA_W(DATA_W)) u_bitmod (
      .word_in  (dn_rdata),
      .pos      (tgt_pos),
      .new_val  (up_wdata[0]),
      .bit_out  (tgt_bit),
      .word_out (mod_word)
   );

   bab_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (up_valid),
      .req_we    (up_we),
      .req_alias (is_alias),
      .tgt_ready (dn_ready),
      .state     (state)
   );

   // modified word is latched on the read handshake of an alias write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   mod_q <= '0;
      else if (state == ST_RD && dn_ready && up_we) mod_q <= mod_word;
   end

   always_comb begin
      dn_valid = (state != ST_IDLE);
      dn_addr  = (state == ST_PASS) ? up_addr  : tgt_addr;
      dn_we    = (state == ST_PASS) ? up_we    : (state == ST_WR);
      dn_wdata = (state == ST_PASS) ? up_wdata : mod_q;
      up_ready = dn_ready && ((state == ST_PASS) || (state == ST_WR) ||
                              (state == ST_RD && !up_we));
      up_rdata = (state == ST_PASS) ? dn_rdata : {{(DATA_W-1){1'b0}}, tgt_bit};
   end
endmodule

// File: rtl/bab_checker.sv
module bab_checker #(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       BAND_LOG2  = 20,
   parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h4200_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              up_valid,
   input logic              up_ready,
   input logic [ADDR_W-1:0] up_addr,
   input logic              up_we,
   input logic [DATA_W-1:0] up_rdata,
   input logic              dn_valid,
   input logic              dn_ready,
   input logic [ADDR_W-1:0] dn_addr,
   input logic              dn_we,
   input logic [DATA_W-1:0] dn_wdata,
   input logic [DATA_W-1:0] dn_rdata
);
   localparam int unsigned   SPAN_LOG2 = BAND_LOG2 + 5;
   localparam logic [ADDR_W:0] WIN_LO = {1'b0, ALIAS_BASE};
   localparam logic [ADDR_W:0] WIN_HI = WIN_LO + ((ADDR_W+1)'(1) << SPAN_LOG2);

   logic in_win;
   logic alias_wr_rd_hs;
   assign in_win = ({1'b0, up_addr} >= WIN_LO) && ({1'b0, up_addr} < WIN_HI);
   assign alias_wr_rd_hs = up_valid && up_we && in_win && dn_valid && dn_ready && !dn_we;

   AST_PASS_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !in_win && dn_valid) |-> (dn_addr == up_addr && dn_we == up_we)); // R2

   AST_READ_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (up_ready && !up_we && in_win) |-> (up_rdata[DATA_W-1:1] == '0)); // R5

   AST_RMW_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      alias_wr_rd_hs |=> (dn_valid && dn_we && dn_addr == $past(dn_addr))); // R6

   AST_RMW_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      alias_wr_rd_hs |=> ($countones(dn_wdata ^ $past(dn_rdata)) <= 1)); // R6

   AST_RMW_HOLD_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_we && in_win && dn_valid && !dn_we) |-> !up_ready); // R8

   AST_READY_NEEDS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      up_ready |-> (up_valid && dn_valid && dn_ready)); // R8
endmodule

bind bitalias_bridge bab_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BAND_LOG2(BAND_LOG2), .ALIAS_BASE(ALIAS_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
   .up_addr(up_addr), .up_we(up_we), .up_rdata(up_rdata),
   .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_we(dn_we),
   .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
);

// File: tb/bitalias_bridge_tb.sv
`timescale 1ns/1ps
module bitalias_bridge_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        up_valid = 1'b0;
   logic        up_ready;
   logic [31:0] up_addr = '0;
   logic        up_we = 1'b0;
   logic [31:0] up_wdata = '0;
   logic [31:0] up_rdata;
   logic        dn_valid;
   logic        dn_ready;
   logic [31:0] dn_addr;
   logic        dn_we;
   logic [31:0] dn_wdata;
   logic [31:0] dn_rdata;

   int errors = 0;
   int checks = 0;
   logic stall = 1'b0;
   logic [31:0] mem [16];
   logic [1:0]  cyc;
   logic [31:0] tr_addr [4];
   logic        tr_we   [4];
   int          tr_n;

   always #2.5 clk = ~clk;

   bitalias_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
      .up_addr(up_addr), .up_we(up_we), .up_wdata(up_wdata), .up_rdata(up_rdata),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_we(dn_we),
      .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
   );

   // target model: 16 words selected by address bits [5:2]
   assign dn_rdata = mem[dn_addr[5:2]];
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= '0;
         cyc <= '0;
         dn_ready <= 1'b1;
      end else begin
         cyc <= cyc + 2'd1;
         dn_ready <= stall ? (cyc != 2'd2) : 1'b1;
         if (dn_valid && dn_ready && dn_we) mem[dn_addr[5:2]] <= dn_wdata;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic [31:0] a, input logic w, input logic [31:0] d,
                         output logic [31:0] rd, output int lat);
      @(negedge clk);
      up_valid = 1'b1; up_addr = a; up_we = w; up_wdata = d;
      tr_n = 0; lat = 0;
      forever begin
         @(negedge clk);
         lat++;
         if (dn_valid && dn_ready && tr_n < 4) begin
            tr_addr[tr_n] = dn_addr; tr_we[tr_n] = dn_we; tr_n++;
         end
         if (up_ready) break;
      end
      rd = up_rdata;
      @(negedge clk);
      up_valid = 1'b0;
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
      finish_run();
   end

   // vector table: address, write, write data, expected value, model index
   // reads compare up_rdata; writes compare the model word afterwards
   localparam int NV = 9;
   localparam logic [31:0] V_ADDR [NV] = '{32'h4000_0004, 32'h4000_0004, 32'h4200_008C,
      32'h4200_00A0, 32'h4200_00A0, 32'h4200_00F0, 32'h4000_0004, 32'h4200_079C, 32'h4200_079C};
   localparam logic        V_WE   [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
   localparam logic [31:0] V_WD   [NV] = '{32'h1234_5678, 32'h0, 32'h0, 32'h0,
      32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0, 32'h0000_0001, 32'h0};
   localparam logic [31:0] V_EXP  [NV] = '{32'h1234_5678, 32'h1234_5678, 32'h1, 32'h0,
      32'h1234_5778, 32'h0234_5778, 32'h0234_5778, 32'h0000_0080, 32'h1};
   localparam int          V_IDX  [NV] = '{1, 1, 1, 1, 1, 1, 1, 15, 15};
   localparam string       V_REQ  [NV] = '{"R2", "R2", "R5", "R5", "R6", "R7", "R2", "R4", "R5"};

   initial begin
      logic [31:0] rd;
      int lat;
      repeat (3) @(negedge clk);
      chk(up_ready == 1'b0 && dn_valid == 1'b0, "R1", {30'b0, up_ready, dn_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(up_ready == 1'b0 && dn_valid == 1'b0, "R1", {30'b0, up_ready, dn_valid}, 32'h0);

      for (int v = 0; v < NV; v++) begin
         access(V_ADDR[v], V_WE[v], V_WD[v], rd, lat);
         if (V_WE[v]) chk(mem[V_IDX[v]] == V_EXP[v], V_REQ[v], mem[V_IDX[v]], V_EXP[v]);
         else         chk(rd == V_EXP[v], V_REQ[v], rd, V_EXP[v]);
      end

      // R2 latency and forwarding for a pass-through read
      access(32'h4000_0004, 1'b0, 32'h0, rd, lat);
      chk(lat == 1, "R2", lat, 1);
      chk(tr_n == 1 && tr_addr[0] == 32'h4000_0004 && !tr_we[0], "R2", tr_addr[0], 32'h4000_0004);

      // R3 first address above the window goes through as a full write
      access(32'h4400_0000, 1'b1, 32'hDEAD_BEEF, rd, lat);
      chk(tr_addr[0] == 32'h4400_0000 && tr_we[0], "R3", tr_addr[0], 32'h4400_0000);
      chk(mem[0] == 32'hDEAD_BEEF, "R3", mem[0], 32'hDEAD_BEEF);
      // R3 last word below the window reads the whole word
      access(32'h41FF_FFFC, 1'b0, 32'h0, rd, lat);
      chk(rd == 32'h0000_0080 && tr_addr[0] == 32'h41FF_FFFC, "R3", rd, 32'h0000_0080);

      // R4 lowest and highest alias words
      access(32'h4200_0000, 1'b0, 32'h0, rd, lat);
      chk(rd == 32'h1 && tr_addr[0] == 32'h4000_0000, "R4", rd, 32'h1);
      chk(lat == 1 && tr_n == 1, "R8", lat, 1);
      access(32'h43FF_FFFC, 1'b0, 32'h0, rd, lat);
      chk(tr_addr[0] == 32'h400F_FFFC, "R4", tr_addr[0], 32'h400F_FFFC);
      chk(rd == 32'h0, "R4", rd, 32'h0);

      // R8 alias write sequence with a ready target
      access(32'h4200_0114, 1'b1, 32'h0000_0001, rd, lat);
      chk(lat == 2, "R8", lat, 2);
      chk(tr_n == 2 && !tr_we[0] && tr_we[1] && tr_addr[0] == 32'h4000_0008 &&
          tr_addr[1] == 32'h4000_0008, "R8", tr_addr[1], 32'h4000_0008);
      chk(mem[2] == 32'h0000_0020, "R6", mem[2], 32'h0000_0020);

      // R8 and R6 with a stalling target
      stall = 1'b1;
      access(32'h4200_0100, 1'b1, 32'hFFFF_FFFF, rd, lat);
      chk(tr_n == 2 && !tr_we[0] && tr_we[1] && lat >= 2, "R8", lat, 2);
      chk(mem[2] == 32'h0000_0021, "R6", mem[2], 32'h0000_0021);
      access(32'h4200_0100, 1'b1, 32'h0000_0000, rd, lat);
      chk(mem[2] == 32'h0000_0020, "R6", mem[2], 32'h0000_0020);
      access(32'h4200_0114, 1'b0, 32'h0, rd, lat);
      chk(rd == 32'h1, "R5", rd, 32'h1);
      access(32'h4000_0008, 1'b0, 32'h0, rd, lat);
      chk(rd == 32'h0000_0020, "R2", rd, 32'h0000_0020);
      stall = 1'b0;

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule